// File: doc/BRIEF.md
# PWM Fault Shutdown Guard

This block sits between a PWM waveform generator and the output pins of one phase leg. Up to twelve external fault lines come in. Software picks, through a primary select mask, which of them are ORed into a combined fault signal. When that combined signal is high and one-shot tripping is enabled, a trip latch is set. The latch forces output A low, and also forces output B low when that option is enabled. The shutdown can take an asynchronous route, so the outputs go low in the same moment the fault appears and not at the next clock edge.

A second, independent path has its own select mask. It is meant to watch one fault line and records in a sticky flag that this line fired. After a trip, the raw fault level may already have gone away, because switching off the outputs often removes the cause. The sticky flags keep a record of which path saw the fault. The trip latch and both flags stay set until software writes 1 to their clear bits. A level interrupt request reports enabled flags. A software force input can set the trip directly.

Top module: `pwm_trip_guard`

## Requirements
- R1: After reset both select masks and all control bits are 0, the trip latch and both flags are clear, tripIrq is 0, and pwmAOut/pwmBOut equal pwmAIn/pwmBIn.
- R2: The primary fault is the OR of the tripIn bits whose bit is set in the primary mask (address 0). A fault on an unmasked input sets no flag and leaves the outputs passing.
- R3: A primary fault held through one rising clock edge sets primFlag within three further edges. primFlag stays set after the fault input drops.
- R4: When control bit 0 (one-shot enable) is set, a primary fault sets the trip latch (tripActive). The latch forces pwmAOut low. It forces pwmBOut low only when control bit 1 (force-B enable) is set; otherwise pwmBOut follows pwmBIn.
- R5: When control bit 2 (async route) and bit 0 are set, pwmAOut goes low combinationally while the raw primary fault is high, before any clock edge. With bit 2 clear, the output stays high until the trip latch is set.
- R6: The secondary path ORs the tripIn bits set in the secondary mask (address 1) and sets secFlag, which is sticky. A primary fault on an input outside the secondary mask leaves secFlag clear.
- R7: Writing address 3 with bit 0, bit 1 or bit 2 set clears the trip latch, primFlag or secFlag respectively. A set condition in the same cycle wins, and the state stays set.
- R8: A one-cycle pulse on swForce sets the trip latch, with the same output action as a hardware trip.
- R9: tripIrq is high exactly when (primFlag and control bit 3) or (secFlag and control bit 4).
- R10: With control bit 0 clear, a primary fault still sets primFlag but does not set the trip latch, and the outputs keep passing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tripIn | input | 12 | External fault lines, active high |
| pwmAIn | input | 1 | Output A from the waveform generator |
| pwmBIn | input | 1 | Output B from the waveform generator |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 primary mask, 1 secondary mask, 2 control, 3 clear |
| regWrData | input | 12 | Register write data |
| swForce | input | 1 | Software force of the trip latch |
| pwmAOut | output | 1 | Output A after the trip override |
| pwmBOut | output | 1 | Output B after the trip override |
| tripActive | output | 1 | Trip latch state |
| primFlag | output | 1 | Sticky primary-path flag |
| secFlag | output | 1 | Sticky secondary-path flag |
| tripIrq | output | 1 | Level interrupt request |

## Verification
The bench pulses a fault for one cycle and checks the flags after the line has dropped. A design that reported the raw level would show nothing by then. It holds a fault high while writing a clear, to catch a design where the clear beats the set and a live fault goes unrecorded. It faults an input that the primary mask selects but the secondary mask does not, to check that the secondary flag identifies only its own source. It also probes the outputs one time-step after the fault is driven, to separate the asynchronous shutdown from the clocked one. Other checks cover the output B option and the interrupt gating.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_PRIM_MASK = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SEC_MASK  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL      = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR     = 2'd3;

  typedef struct packed {
    logic secIrqEn;
    logic primIrqEn;
    logic asyncRoute;
    logic forceBEn;
    logic oneShotEn;
  } tripCfg_t;

  localparam int CFG_W = $bits(tripCfg_t);

  typedef struct packed {
    logic forceTrip;
    logic clrSec;
    logic clrPrim;
    logic clrTrip;
  } tripStrobe_t;
endpackage

// File: rtl/pwm_trip_ctrl.sv
module pwm_trip_ctrl
  import pwm_trip_pkg::*;
#(
  parameter int NUM_TRIP = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [NUM_TRIP-1:0] regWrData,
  input  logic                swForce,
  output logic [NUM_TRIP-1:0] primMask,
  output logic [NUM_TRIP-1:0] secMask,
  output tripCfg_t            cfg,
  output tripStrobe_t         strobes
);
  logic unusedHiBits;
  assign unusedHiBits = ^regWrData[NUM_TRIP-1:CFG_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primMask <= '0;
      secMask  <= '0;
      cfg      <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_PRIM_MASK: primMask <= regWrData;
        ADDR_SEC_MASK:  secMask  <= regWrData;
        ADDR_CTRL:      cfg      <= tripCfg_t'(regWrData[CFG_W-1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    strobes = '0;
    strobes.forceTrip = swForce;
    if (regWrEn && regAddr == ADDR_CLEAR) begin
      strobes.clrTrip = regWrData[0];
      strobes.clrPrim = regWrData[1];
      strobes.clrSec  = regWrData[2];
    end
  end

  AST_CLEAR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrTrip || strobes.clrPrim || strobes.clrSec) |-> regWrEn) else $error("clear strobe without write"); // R7
endmodule

// File: rtl/pwm_trip_datapath.sv
module pwm_trip_datapath
  import pwm_trip_pkg::*;
#(
  parameter int NUM_TRIP    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TRIP-1:0] tripIn,
  input  logic [NUM_TRIP-1:0] primMask,
  input  logic [NUM_TRIP-1:0] secMask,
  input  tripCfg_t            cfg,
  input  tripStrobe_t         strobes,
  input  logic                pwmAIn,
  input  logic                pwmBIn,
  output logic                pwmAOut,
  output logic                pwmBOut,
  output logic                tripActive,
  output logic                primFlag,
  output logic                secFlag,
  output logic                tripIrq
);
  logic primRaw, secRaw;
  logic primSync, secSync;
  logic [SYNC_STAGES-1:0] primPipe, secPipe;
  logic forceLow;

  assign primRaw = |(tripIn & primMask);
  assign secRaw  = |(tripIn & secMask);

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          primPipe <= '0;
          secPipe  <= '0;
        end else begin
          primPipe <= primRaw;
          secPipe  <= secRaw;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          primPipe <= '0;
          secPipe  <= '0;
        end else begin
          primPipe <= {primPipe[SYNC_STAGES-2:0], primRaw};
          secPipe  <= {secPipe[SYNC_STAGES-2:0], secRaw};
        end
      end
    end
  endgenerate

  assign primSync = primPipe[SYNC_STAGES-1];
  assign secSync  = secPipe[SYNC_STAGES-1];

  // Sticky state: a set in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tripActive <= 1'b0;
      primFlag   <= 1'b0;
      secFlag    <= 1'b0;
    end else begin
      tripActive <= (cfg.oneShotEn && primSync) || strobes.forceTrip ||
                    (tripActive && !strobes.clrTrip);
      primFlag   <= primSync || (primFlag && !strobes.clrPrim);
      secFlag    <= secSync  || (secFlag  && !strobes.clrSec);
    end
  end

  // Async route overrides the outputs directly from the raw combined fault.
  assign forceLow = tripActive || (cfg.asyncRoute && cfg.oneShotEn && primRaw);
  assign pwmAOut  = pwmAIn && !forceLow;
  assign pwmBOut  = pwmBIn && !(forceLow && cfg.forceBEn);
  assign tripIrq  = (primFlag && cfg.primIrqEn) || (secFlag && cfg.secIrqEn);

  AST_PRIM_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    primSync |=> primFlag) else $error("primary flag missed"); // R3
  AST_PRIM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (primFlag && !strobes.clrPrim) |=> primFlag) else $error("primary flag lost"); // R3
  AST_SEC_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (secFlag && !strobes.clrSec) |=> secFlag) else $error("secondary flag lost"); // R6
  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (tripActive && !strobes.clrTrip) |=> tripActive) else $error("trip lost"); // R7
  AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.forceTrip |=> tripActive) else $error("force ignored"); // R8
  AST_TRIP_A_LOW: assert property (@(posedge clk) disable iff (!rstN)
    tripActive |-> !pwmAOut) else $error("A not forced low"); // R4
  AST_B_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.forceBEn && pwmBIn) |-> pwmBOut) else $error("B overridden"); // R4
  AST_NO_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!primFlag && !secFlag) |-> !tripIrq) else $error("spurious irq"); // R9
endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard
  import pwm_trip_pkg::*;
#(
  parameter int NUM_TRIP    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TRIP-1:0] tripIn,
  input  logic                pwmAIn,
  input  logic                pwmBIn,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [NUM_TRIP-1:0] regWrData,
  input  logic                swForce,
  output logic                pwmAOut,
  output logic                pwmBOut,
  output logic                tripActive,
  output logic                primFlag,
  output logic                secFlag,
  output logic                tripIrq
);
  logic [NUM_TRIP-1:0] primMask, secMask;
  tripCfg_t            cfg;
  tripStrobe_t         strobes;

  pwm_trip_ctrl #(.NUM_TRIP(NUM_TRIP)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .swForce(swForce), .primMask(primMask),
    .secMask(secMask), .cfg(cfg), .strobes(strobes)
  );

  pwm_trip_datapath #(.NUM_TRIP(NUM_TRIP), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .tripIn(tripIn), .primMask(primMask),
    .secMask(secMask), .cfg(cfg), .strobes(strobes), .pwmAIn(pwmAIn),
    .pwmBIn(pwmBIn), .pwmAOut(pwmAOut), .pwmBOut(pwmBOut),
    .tripActive(tripActive), .primFlag(primFlag), .secFlag(secFlag),
    .tripIrq(tripIrq)
  );
endmodule

// File: tb/test_pwm_trip_guard.sv
module test_pwm_trip_guard;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] tripIn = '0;
  logic pwmAIn = 1'b1, pwmBIn = 1'b1;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [11:0] regWrData = '0;
  logic swForce = 1'b0;
  logic pwmAOut, pwmBOut, tripActive, primFlag, secFlag, tripIrq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_trip_guard i_pwm_trip_guard (
    .clk(clk), .rstN(rstN), .tripIn(tripIn), .pwmAIn(pwmAIn), .pwmBIn(pwmBIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .swForce(swForce),
    .pwmAOut(pwmAOut), .pwmBOut(pwmBOut), .tripActive(tripActive),
    .primFlag(primFlag), .secFlag(secFlag), .tripIrq(tripIrq)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulse(input int bitIdx);
    @(negedge clk);
    tripIn[bitIdx] = 1'b1;
    @(negedge clk);
    tripIn[bitIdx] = 1'b0;
    cycles(3);
  endtask

  task automatic clearAll();
    wr(2'd3, 12'h007);
  endtask

  task automatic t_reset();
    check("R1", "pwmAOut", pwmAOut, 1'b1);
    check("R1", "pwmBOut", pwmBOut, 1'b1);
    check("R1", "tripActive", tripActive, 1'b0);
    check("R1", "flags", primFlag | secFlag, 1'b0);
    check("R1", "tripIrq", tripIrq, 1'b0);
  endtask

  task automatic t_mask_ignore();
    wr(2'd0, 12'h008);
    wr(2'd2, 12'h003);
    pulse(5);
    check("R2", "unmasked primFlag", primFlag, 1'b0);
    check("R2", "unmasked pwmAOut", pwmAOut, 1'b1);
  endtask

  task automatic t_identify();
    wr(2'd0, 12'h00F);
    wr(2'd1, 12'h004);
    wr(2'd2, 12'h003);
    pulse(2);
    check("R3", "primFlag after pulse", primFlag, 1'b1);
    check("R6", "secFlag own input", secFlag, 1'b1);
    check("R4", "tripActive", tripActive, 1'b1);
    check("R4", "pwmAOut forced", pwmAOut, 1'b0);
    check("R4", "pwmBOut forced", pwmBOut, 1'b0);
    clearAll();
    check("R7", "trip cleared", tripActive, 1'b0);
    check("R7", "primFlag cleared", primFlag, 1'b0);
    check("R7", "secFlag cleared", secFlag, 1'b0);
    check("R7", "pwmAOut restored", pwmAOut, 1'b1);
    pulse(1);
    check("R6", "secFlag other input", secFlag, 1'b0);
    check("R6", "primFlag other input", primFlag, 1'b1);
    clearAll();
  endtask

  task automatic t_b_option();
    wr(2'd2, 12'h001);
    pulse(0);
    check("R4", "A low without B option", pwmAOut, 1'b0);
    check("R4", "B passes without B option", pwmBOut, 1'b1);
    @(negedge clk); pwmBIn = 1'b0;
    #1 check("R4", "B follows input", pwmBOut, 1'b0);
    pwmBIn = 1'b1;
    clearAll();
  endtask

  task automatic t_set_wins();
    @(negedge clk); tripIn[0] = 1'b1;
    cycles(3);
    clearAll();
    check("R7", "flag held by live fault", primFlag, 1'b1);
    check("R7", "trip held by live fault", tripActive, 1'b1);
    @(negedge clk); tripIn[0] = 1'b0;
    cycles(3);
    clearAll();
    check("R7", "flag clears once fault gone", primFlag, 1'b0);
  endtask

  task automatic t_routes();
    wr(2'd2, 12'h005);
    @(negedge clk); tripIn[0] = 1'b1;
    #1 check("R5", "async A low before edge", pwmAOut, 1'b0);
    check("R5", "latch not yet set", tripActive, 1'b0);
    tripIn[0] = 1'b0;
    cycles(3);
    clearAll();
    wr(2'd2, 12'h001);
    @(negedge clk); tripIn[0] = 1'b1;
    #1 check("R5", "sync A still high", pwmAOut, 1'b1);
    tripIn[0] = 1'b0;
    cycles(3);
    clearAll();
  endtask

  task automatic t_no_oneshot();
    wr(2'd2, 12'h000);
    pulse(0);
    check("R10", "flag without one-shot", primFlag, 1'b1);
    check("R10", "no trip without one-shot", tripActive, 1'b0);
    check("R10", "A passes", pwmAOut, 1'b1);
    clearAll();
  endtask

  task automatic t_force();
    @(negedge clk); swForce = 1'b1;
    @(negedge clk); swForce = 1'b0;
    check("R8", "force sets trip", tripActive, 1'b1);
    check("R8", "force A low", pwmAOut, 1'b0);
    clearAll();
    check("R8", "force cleared", tripActive, 1'b0);
  endtask

  task automatic t_irq();
    wr(2'd1, 12'h004);
    wr(2'd2, 12'h000);
    pulse(0);
    check("R9", "irq masked", tripIrq, 1'b0);
    wr(2'd2, 12'h008);
    check("R9", "irq prim enabled", tripIrq, 1'b1);
    clearAll();
    check("R9", "irq after clear", tripIrq, 1'b0);
    wr(2'd2, 12'h010);
    pulse(0);
    check("R9", "sec enable ignores prim flag", tripIrq, 1'b0);
    pulse(2);
    check("R9", "irq sec enabled", tripIrq, 1'b1);
    clearAll();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cycles(2);
    rstN = 1'b1;
    cycles(1);
    t_reset();
    t_mask_ignore();
    t_identify();
    t_b_option();
    t_set_wins();
    t_routes();
    t_no_oneshot();
    t_force();
    t_irq();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule